// File: doc/BRIEF.md
# Selectable Accumulator Rounding Unit

This unit rounds a 36-bit signed fixed-point accumulator at the point between its middle word (bits 31:16) and its low word (bits 15:0). The 4-bit guard extension (bits 35:32) rides along and takes any carry. A one-bit mode input picks the rule for a low word of exactly one half:

- **Convergent:** resolves the tie toward an even middle word.
- **Two's-complement:** always rounds the tie up.

Every result leaves the low word cleared.

A caller raises `rnd_req_i` for one cycle, with the accumulator and mode presented in the same cycle. One clock later the registered result appears on `res_o` and `res_vld_o` is high for exactly that cycle. The unit serves a plain round, a multiply-with-round and a multiply-accumulate-with-round alike. It needs no knowledge of which operation asked.

The stream interface has no back-pressure. There is no ready signal. A request is accepted in every cycle it is raised, and a result must be consumed in the cycle its valid flag is high, because the flag drops unless another request follows.

Top module: `acc_round_unit`

## Requirements
- R1: `res_vld_o` is high in exactly the cycles that follow a cycle in which `rnd_req_i` was high, and low otherwise.
- R2: With `rnd_mode_i`=0 (convergent) and a low word below 16'h8000, result bits 35:16 equal the input bits 35:16.
- R3: With `rnd_mode_i`=0 and a low word above 16'h8000, result bits 35:16 equal input bits 35:16 plus one.
- R4: With `rnd_mode_i`=0, a low word of exactly 16'h8000 and input bit 16 equal to 0, result bits 35:16 equal input bits 35:16.
- R5: With `rnd_mode_i`=0, a low word of exactly 16'h8000 and input bit 16 equal to 1, result bits 35:16 equal input bits 35:16 plus one, so result bit 16 is 0.
- R6: With `rnd_mode_i`=1 (two's-complement), result bits 35:16 equal input bits 35:16 plus input bit 15. A low word of exactly 16'h8000 therefore always rounds up.
- R7: Whenever `res_vld_o` is high, result bits 15:0 are zero.
- R8: An increment that carries out of bit 31 continues into bits 35:32 and wraps modulo 2^36 with no saturation. For example, 36'hF_FFFF_8000 rounds to 36'h0.
- R9: While the synchronous active-high reset `rst` is high, `res_o` is cleared to zero and `res_vld_o` to 0 on each clock edge, whatever the request input does.
- R10: In a cycle with no request, `res_o` keeps its previous value.
- R11: Negative accumulator values (bit 35 set) follow the same bit-level rules as R2 to R6, with no separate sign handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rnd_req_i | input | 1 | Round request strobe; accumulator and mode are sampled when high |
| rnd_mode_i | input | 1 | 0 = convergent (half to even), 1 = two's-complement (half up) |
| acc_i | input | 36 | Accumulator to round |
| res_o | output | 36 | Rounded accumulator, low word zero |
| res_vld_o | output | 1 | High for one cycle per request, one clock after it |

## Verification
The bench aims at the exact-half low word in both modes and with both parities of bit 16. A design that confused the modes, or that tested the wrong bit for parity, would round a tie in the wrong direction.

It drives low words one step either side of 16'h8000 to catch an off-by-one comparison, which would round 16'h8000 or 16'h8001 wrongly. It rounds all-ones middle words, with the extension both full and empty, to expose a carry that is dropped or saturated instead of wrapping.

Back-to-back and sparse requests, plus stray requests held under reset, show whether the valid flag lingers, goes missing, or lets the result register drift when idle.

// File: rtl/acc_rnd_pkg.sv
package acc_rnd_pkg;
  localparam int unsigned ACC_W_DEF = 36;
  localparam int unsigned LOW_W_DEF = 16;

  typedef enum logic {
    RND_CONV = 1'b0,
    RND_TWOS = 1'b1
  } rnd_mode_e;
endpackage

// File: rtl/acc_rnd_decide.sv
module acc_rnd_decide #(
  parameter int unsigned LOW_W = 16
) (
  input  logic [LOW_W-1:0] low_word,
  input  logic             keep_lsb,
  input  acc_rnd_pkg::rnd_mode_e mode,
  output logic             bump
);
  localparam logic [LOW_W-1:0] HALF = LOW_W'(1) << (LOW_W - 1);

  logic above_half;
  logic at_half;
  logic conv_bump;

  always_comb begin
    above_half = low_word > HALF;
    at_half    = low_word == HALF;
    conv_bump  = above_half | (at_half & keep_lsb);
    if (mode == acc_rnd_pkg::RND_TWOS) bump = low_word[LOW_W-1];
    else                               bump = conv_bump;
  end
endmodule

// File: rtl/acc_rnd_incr.sv
module acc_rnd_incr #(
  parameter int unsigned ACC_W = 36,
  parameter int unsigned LOW_W = 16
) (
  input  logic [ACC_W-1:0] acc,
  input  logic             bump,
  output logic [ACC_W-1:0] rounded
);
  localparam int unsigned HI_W = ACC_W - LOW_W;

  logic [HI_W-1:0] upper;
  logic [HI_W-1:0] upper_inc;

  always_comb begin
    upper     = acc[ACC_W-1:LOW_W];
    upper_inc = upper + {{(HI_W-1){1'b0}}, bump};
    rounded   = {upper_inc, {LOW_W{1'b0}}};
  end
endmodule

// File: rtl/acc_rnd_stage.sv
module acc_rnd_stage #(
  parameter int unsigned ACC_W = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ACC_W-1:0] d,
  output logic [ACC_W-1:0] q,
  output logic             q_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      q_vld <= 1'b0;
    end else begin
      q_vld <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/acc_round_unit.sv
module acc_round_unit #(
  parameter int unsigned ACC_W = acc_rnd_pkg::ACC_W_DEF,
  parameter int unsigned LOW_W = acc_rnd_pkg::LOW_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rnd_req_i,
  input  logic             rnd_mode_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [ACC_W-1:0] res_o,
  output logic             res_vld_o
);
  logic             bump;
  logic [ACC_W-1:0] rounded;
  acc_rnd_pkg::rnd_mode_e mode;

  assign mode = acc_rnd_pkg::rnd_mode_e'(rnd_mode_i);

  acc_rnd_decide #(.LOW_W(LOW_W)) decide_i (
    .low_word (acc_i[LOW_W-1:0]),
    .keep_lsb (acc_i[LOW_W]),
    .mode     (mode),
    .bump     (bump)
  );

  acc_rnd_incr #(.ACC_W(ACC_W), .LOW_W(LOW_W)) incr_i (
    .acc     (acc_i),
    .bump    (bump),
    .rounded (rounded)
  );

  acc_rnd_stage #(.ACC_W(ACC_W)) stage_i (
    .clk   (clk),
    .rst   (rst),
    .load  (rnd_req_i),
    .d     (rounded),
    .q     (res_o),
    .q_vld (res_vld_o)
  );
endmodule

// File: rtl/acc_round_chk.sv
module acc_round_chk #(
  parameter int unsigned ACC_W = 36,
  parameter int unsigned LOW_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rnd_req_i,
  input logic             rnd_mode_i,
  input logic [ACC_W-1:0] acc_i,
  input logic [ACC_W-1:0] res_o,
  input logic             res_vld_o
);
  localparam int unsigned HI_W = ACC_W - LOW_W;
  localparam logic [LOW_W-1:0] HALF = LOW_W'(1) << (LOW_W - 1);

  AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    rnd_req_i |=> res_vld_o);  // R1
  AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rnd_req_i |=> !res_vld_o);  // R1
  AST_CONV_BELOW: assert property (@(posedge clk) disable iff (rst)
    (rnd_req_i && !rnd_mode_i && acc_i[LOW_W-1:0] < HALF)
    |=> res_o[ACC_W-1:LOW_W] == $past(acc_i[ACC_W-1:LOW_W]));  // R2
  AST_CONV_ABOVE: assert property (@(posedge clk) disable iff (rst)
    (rnd_req_i && !rnd_mode_i && acc_i[LOW_W-1:0] > HALF)
    |=> res_o[ACC_W-1:LOW_W] == HI_W'($past(acc_i[ACC_W-1:LOW_W]) + 1'b1));  // R3
  AST_TIE_EVEN: assert property (@(posedge clk) disable iff (rst)
    (rnd_req_i && !rnd_mode_i && acc_i[LOW_W-1:0] == HALF && !acc_i[LOW_W])
    |=> res_o[ACC_W-1:LOW_W] == $past(acc_i[ACC_W-1:LOW_W]));  // R4
  AST_TIE_ODD: assert property (@(posedge clk) disable iff (rst)
    (rnd_req_i && !rnd_mode_i && acc_i[LOW_W-1:0] == HALF && acc_i[LOW_W])
    |=> !res_o[LOW_W]);  // R5
  AST_TWOS_UP: assert property (@(posedge clk) disable iff (rst)
    (rnd_req_i && rnd_mode_i && acc_i[LOW_W-1])
    |=> res_o[ACC_W-1:LOW_W] == HI_W'($past(acc_i[ACC_W-1:LOW_W]) + 1'b1));  // R6
  AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    res_vld_o |-> res_o[LOW_W-1:0] == '0);  // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !res_vld_o));  // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rnd_req_i |=> $stable(res_o));  // R10
endmodule

bind acc_round_unit acc_round_chk #(.ACC_W(ACC_W), .LOW_W(LOW_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .rnd_req_i (rnd_req_i),
  .rnd_mode_i(rnd_mode_i),
  .acc_i     (acc_i),
  .res_o     (res_o),
  .res_vld_o (res_vld_o)
);

// File: tb/acc_round_unit_tb.sv
module acc_round_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        mode = 1'b0;
  logic [35:0] acc = '0;
  logic [35:0] res;
  logic        vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          vld;
    logic [35:0] res;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [35:0] last_res = '0;

  always #5 clk = ~clk;

  acc_round_unit dut_i (
    .clk(clk), .rst(rst), .rnd_req_i(req), .rnd_mode_i(mode),
    .acc_i(acc), .res_o(res), .res_vld_o(vld)
  );

  function automatic logic [35:0] model(logic [35:0] a, logic m);
    logic [19:0] hi;
    logic [15:0] lo;
    logic        up;
    hi = a[35:16];
    lo = a[15:0];
    if (m) up = lo[15];
    else   up = (lo > 16'h8000) || (lo == 16'h8000 && hi[0]);
    return {hi + {19'd0, up}, 16'h0000};
  endfunction

  function automatic string classify(logic [35:0] a, logic m);
    if (m) return "R6";
    if (a[15:0] < 16'h8000) return "R2";
    if (a[15:0] > 16'h8000) return "R3";
    if (a[16]) return "R5";
    return "R4";
  endfunction

  task automatic drive(bit r, logic m, logic [35:0] a, string tag);
    exp_t e;
    @(negedge clk);
    req  = r;
    mode = m;
    acc  = a;
    if (r) last_res = model(a, m);
    e.vld = r;
    e.res = last_res;
    e.tag = r ? tag : {tag, "/R1/R10"};
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (vld !== e.vld || res !== e.res || (vld && res[15:0] !== 16'h0)) begin
        fails++;
        $display("FAIL %s (R7/R1): vld=%0b res=%h expected vld=%0b res=%h",
                 e.tag, vld, res, e.vld, e.res);
      end
    end
  end

  task automatic check_reset(string tag);
    checks++;
    if (res !== 36'h0 || vld !== 1'b0) begin
      fails++;
      $display("FAIL %s: vld=%0b res=%h expected vld=0 res=0", tag, vld, res);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9: reset dominates a stray request
    @(negedge clk);
    req  = 1'b1;
    acc  = 36'h1_2345_FFFF;
    repeat (3) @(negedge clk);
    check_reset("R9");
    req = 1'b0;
    rst = 1'b0;

    drive(1, 0, 36'h0_0001_7FFF, "R2");
    drive(1, 0, 36'h0_0001_8001, "R3");
    drive(1, 0, 36'h0_0004_8000, "R4");
    drive(1, 0, 36'h0_0005_8000, "R5");
    drive(1, 1, 36'h0_0004_8000, "R6 tie");
    drive(1, 1, 36'h0_0004_7FFF, "R6 below");
    drive(1, 1, 36'h0_0004_FFFF, "R6 above");
    drive(0, 0, 36'h0_0000_0000, "R1 idle");
    drive(0, 1, 36'hF_FFFF_FFFF, "R10 idle");
    drive(1, 0, 36'hF_FFFF_8000, "R8 wrap");
    drive(1, 1, 36'h0_FFFF_8000, "R8 ext");
    drive(1, 0, 36'h8_0001_C000, "R11 neg");
    drive(1, 0, 36'hF_FFFE_8000, "R11 neg tie");
    drive(1, 1, 36'hF_FFFE_8000, "R11 neg twos");
    drive(1, 0, 36'h0_0000_0000, "R2 zero");
    drive(0, 0, 36'h0_0003_9000, "R1 gap");
    drive(1, 0, 36'h0_0003_9000, "R3 again");

    for (int i = 0; i < 300; i++) begin
      logic [35:0] a;
      logic        m;
      bit          r;
      a = {$urandom_range(15, 0), $urandom()};
      if (i % 4 == 0) a[15:0] = 16'h8000;
      m = $urandom_range(1, 0);
      r = ($urandom_range(3, 0) != 0);
      drive(r, m, a, classify(a, m));
    end

    drive(0, 0, 36'h0, "R1 drain");
    repeat (3) @(negedge clk);

    // R9: mid-run reset with a request pending
    req = 1'b1;
    acc = 36'h0_0007_9000;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset("R9 mid-run");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule